// File: doc/BRIEF.md
# Audio Tone-Shift Bit Demodulator with Clock Recovery

This block turns a stream of raw 12-bit unsigned converter samples, carrying a two-tone frequency-shift keyed signal at eight samples per bit, into a recovered bit stream with one strobe per bit.

The input stage tracks the DC level of the input and subtracts it. The level is a running average over fixed windows of samples, with a fallback value for averages that are out of range. The corrected sample is scaled down to a signed byte. Frequency is discriminated by multiplying each byte with the byte from half a bit period earlier. The product is smoothed by a first-order recursive low-pass filter in Q8 fixed point, and the sign of the filter output is sliced into a history register.

A phase counter advances on every sample and is nudged towards the slicer's transitions. Each time it wraps, a majority vote over recent slicer bits gives a recovered level. The output bit is 1 when that level equals the previous one, so the bit is decoded from level changes. Framing is left to downstream logic.

Top module: `afskDemodulator`

## Requirements
- R1: Each input sample is corrected as d = adcSample − offset (signed), shifted arithmetically right by 4, and clamped to the signed byte range −128..127.
- R2: The offset is 2303 after reset. Samples are summed in consecutive windows of 192, counted from reset. At the end of each window the offset becomes floor(sum/192) when that value lies in 1300..3300 inclusive, and 2303 otherwise. The new offset applies from the next sample.
- R3: The discriminator product is the current byte times the byte from four samples earlier. Positions not yet filled since reset count as zero.
- R4: Filter: x = floor(product·42/256) and y = x_prev + x + floor(y_prev·171/256), with y saturated to the signed 16-bit range. x_prev and y_prev are 0 after reset. The sliced bit is 1 when y > 0.
- R5: A phase counter starts at 0 and gains 32 per sample. It is adjusted first when the two newest sliced bits differ: +4 if it is below 128, −4 otherwise. A sum of 256 or more wraps by −256 and marks a bit decision.
- R6: At a decision the recovered level is 1 when at least 3 of the 5 newest sliced bits are 1.
- R7: At a decision bitOut becomes 1 if the recovered level equals the previous recovered level, and 0 if it differs. The previous level is 0 after reset. Between decisions bitOut holds.
- R8: bitValid is high for exactly one cycle per decision: the cycle after the third rising edge counted from the edge that captured the deciding sample. It is low at all other times.
- R9: While rstN is low, bitValid and bitOut are 0.
- R10: With a constant input equal to the offset, a decision occurs on every 8th sample after reset, and each one gives bitOut = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | Qualifies adcSample for one cycle |
| adcSample | input | 12 | Unsigned converter sample |
| bitValid | output | 1 | One-cycle strobe per recovered bit |
| bitOut | output | 1 | Decoded bit, valid with bitValid and held after |

## Verification
A sample captured at one rising edge passes through three registers in turn: the corrected byte, the filter and slicer state, and the decision output. Its effect on bitValid and bitOut is therefore due in the cycle after the third edge. The bench drives each sample on a falling edge and samples the outputs on the third falling edge after it. One falling edge later it checks that the strobe has already dropped. Samples are spaced four cycles apart, so each result can be attributed to a single sample, and a bench model written from the requirements supplies the expected values at exactly those points.

// File: rtl/afskDemodPkg.sv
package afskDemodPkg;
  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic filtEn;    // corrected byte ready: run delay line, filter, slicer
    logic decideEn;  // phase wrap: vote and decode one bit
  } afskStrobes_t;
endpackage

// File: rtl/afskFrontEnd.sv
module afskFrontEnd #(
  parameter int ADC_W   = 12,
  parameter int OUT_W   = 8,
  parameter int SHIFT   = 4,
  parameter int WIN     = 192,
  parameter int OFS_MIN = 1300,
  parameter int OFS_MAX = 3300,
  parameter int OFS_DEF = 2303
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic [ADC_W-1:0]        adcIn,
  output logic signed [OUT_W-1:0] sampleOut,
  output logic [ADC_W-1:0]        offsetOut
);
  localparam int CNT_W = $clog2(WIN);
  localparam int SUM_W = ADC_W + CNT_W;
  localparam logic [SUM_W-1:0] WinDiv = SUM_W'(WIN);
  localparam logic signed [ADC_W:0] SatHi = (ADC_W+1)'(2**(OUT_W-1) - 1);
  localparam logic signed [ADC_W:0] SatLo = (ADC_W+1)'(-(2**(OUT_W-1)));

  logic [CNT_W-1:0] winCount;
  logic [SUM_W-1:0] winSum, sumNext, avgWide;
  logic [ADC_W-1:0] offsetReg;
  logic signed [ADC_W:0] diff, shifted;
  logic signed [OUT_W-1:0] clamped;
  logic avgInRange;

  always_comb begin
    diff    = $signed({1'b0, adcIn}) - $signed({1'b0, offsetReg});
    shifted = diff >>> SHIFT;
    if (shifted > SatHi)      clamped = SatHi[OUT_W-1:0];
    else if (shifted < SatLo) clamped = SatLo[OUT_W-1:0];
    else                      clamped = shifted[OUT_W-1:0];
    sumNext    = winSum + SUM_W'(adcIn);
    avgWide    = sumNext / WinDiv;
    avgInRange = (avgWide >= SUM_W'(OFS_MIN)) && (avgWide <= SUM_W'(OFS_MAX));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCount  <= '0;
      winSum    <= '0;
      offsetReg <= ADC_W'(OFS_DEF);
      sampleOut <= '0;
    end else if (inValid) begin
      sampleOut <= clamped;
      if (winCount == CNT_W'(WIN - 1)) begin
        winCount  <= '0;
        winSum    <= '0;
        offsetReg <= avgInRange ? avgWide[ADC_W-1:0] : ADC_W'(OFS_DEF);
      end else begin
        winCount <= winCount + 1'b1;
        winSum   <= sumNext;
      end
    end
  end

  assign offsetOut = offsetReg;
endmodule

// File: rtl/afskDatapath.sv
module afskDatapath import afskDemodPkg::*; #(
  parameter int SAMPLE_W = 8,
  parameter int DELAY    = 4,
  parameter int FILT_W   = 16,
  parameter int FRAC     = 8,
  parameter int COEF_X   = 42,
  parameter int COEF_Y   = 171,
  parameter int HIST_W   = 8,
  parameter int MAJ_N    = 5,
  parameter int MAJ_MIN  = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  afskStrobes_t               strobes,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  output logic [HIST_W-1:0]          sampledBits,
  output logic                       bitOut,
  output logic                       bitValid
);
  localparam int COEF_W = $clog2((COEF_X > COEF_Y ? COEF_X : COEF_Y) + 1) + 1;
  localparam int PROD_W = 2 * SAMPLE_W;
  localparam int MULX_W = PROD_W + COEF_W;
  localparam int MULY_W = FILT_W + COEF_W;
  localparam int SUM_W  = FILT_W + 2;
  localparam logic signed [COEF_W-1:0] CoefX = COEF_W'(COEF_X);
  localparam logic signed [COEF_W-1:0] CoefY = COEF_W'(COEF_Y);
  localparam logic signed [SUM_W-1:0] YMax = SUM_W'(2**(FILT_W-1) - 1);
  localparam logic signed [SUM_W-1:0] YMin = SUM_W'(-(2**(FILT_W-1)));

  logic [DELAY*SAMPLE_W-1:0] delayChain;
  logic signed [SAMPLE_W-1:0] delayed;
  logic signed [PROD_W-1:0]  prod;
  logic signed [MULX_W-1:0]  scaledX;
  logic signed [MULY_W-1:0]  scaledY;
  logic signed [FILT_W-1:0]  xPrev, yPrev, xNew, yNew;
  logic signed [SUM_W-1:0]   ySum;
  logic majorityBit, lastLevel;

  always_comb begin
    delayed = delayChain[DELAY*SAMPLE_W-1 -: SAMPLE_W];
    prod    = sampleIn * delayed;
    scaledX = prod * CoefX;
    xNew    = FILT_W'(scaledX >>> FRAC);
    scaledY = yPrev * CoefY;
    ySum    = SUM_W'(xPrev) + SUM_W'(xNew) + SUM_W'(scaledY >>> FRAC);
    if (ySum > YMax)      yNew = YMax[FILT_W-1:0];
    else if (ySum < YMin) yNew = YMin[FILT_W-1:0];
    else                  yNew = ySum[FILT_W-1:0];
    majorityBit = ($countones(sampledBits[MAJ_N-1:0]) >= MAJ_MIN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      delayChain  <= '0;
      xPrev       <= '0;
      yPrev       <= '0;
      sampledBits <= '0;
    end else if (strobes.filtEn) begin
      delayChain  <= {delayChain[(DELAY-1)*SAMPLE_W-1:0], sampleIn};
      xPrev       <= xNew;
      yPrev       <= yNew;
      sampledBits <= {sampledBits[HIST_W-2:0], (yNew > 0)};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastLevel <= 1'b0;
      bitOut    <= 1'b0;
      bitValid  <= 1'b0;
    end else begin
      bitValid <= strobes.decideEn;
      if (strobes.decideEn) begin
        lastLevel <= majorityBit;
        bitOut    <= (majorityBit == lastLevel);
      end
    end
  end
endmodule

// File: rtl/afskControl.sv
module afskControl import afskDemodPkg::*; #(
  parameter int PHASE_MAX    = 256,
  parameter int PHASE_STEP   = 32,
  parameter int PHASE_THRESH = 128,
  parameter int PHASE_ADJ    = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sampleValid,
  input  logic [1:0]   recentBits,
  output afskStrobes_t strobes
);
  localparam int PH_W = $clog2(PHASE_MAX);
  localparam int SUM_W = PH_W + 2;

  logic frontDone, filtDone;
  logic [PH_W-1:0]  phase;
  logic [SUM_W-1:0] phaseAdj, phaseSum, phaseNext;
  logic wrap;

  always_comb begin
    if (recentBits[1] ^ recentBits[0])
      phaseAdj = (phase < PH_W'(PHASE_THRESH)) ? SUM_W'(phase) + SUM_W'(PHASE_ADJ)
                                               : SUM_W'(phase) - SUM_W'(PHASE_ADJ);
    else
      phaseAdj = SUM_W'(phase);
    phaseSum  = phaseAdj + SUM_W'(PHASE_STEP);
    wrap      = (phaseSum >= SUM_W'(PHASE_MAX));
    phaseNext = wrap ? phaseSum - SUM_W'(PHASE_MAX) : phaseSum;
    strobes.filtEn   = frontDone;
    strobes.decideEn = filtDone && wrap;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frontDone <= 1'b0;
      filtDone  <= 1'b0;
      phase     <= '0;
    end else begin
      frontDone <= sampleValid;
      filtDone  <= frontDone;
      if (filtDone) phase <= phaseNext[PH_W-1:0];
    end
  end
endmodule

// File: rtl/afskDemodulator.sv
module afskDemodulator import afskDemodPkg::*; #(
  parameter int ADC_W        = 12,
  parameter int SAMPLE_W     = 8,
  parameter int OFS_WIN      = 192,
  parameter int OFS_MIN      = 1300,
  parameter int OFS_MAX      = 3300,
  parameter int OFS_DEF      = 2303,
  parameter int PHASE_MAX    = 256,
  parameter int PHASE_STEP   = 32,
  parameter int PHASE_THRESH = 128,
  parameter int PHASE_ADJ    = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleValid,
  input  logic [ADC_W-1:0] adcSample,
  output logic             bitValid,
  output logic             bitOut
);
  localparam int SHIFT  = ADC_W - SAMPLE_W;
  localparam int SPB    = PHASE_MAX / PHASE_STEP;
  localparam int DELAY  = SPB / 2;
  localparam int HIST_W = 8;

  afskStrobes_t strobes;
  logic signed [SAMPLE_W-1:0] sampleByte;
  logic [ADC_W-1:0]  offsetValue;
  logic [HIST_W-1:0] sampledBits;

  afskFrontEnd #(
    .ADC_W(ADC_W), .OUT_W(SAMPLE_W), .SHIFT(SHIFT), .WIN(OFS_WIN),
    .OFS_MIN(OFS_MIN), .OFS_MAX(OFS_MAX), .OFS_DEF(OFS_DEF)
  ) uFront (
    .clk(clk), .rstN(rstN), .inValid(sampleValid), .adcIn(adcSample),
    .sampleOut(sampleByte), .offsetOut(offsetValue)
  );

  afskControl #(
    .PHASE_MAX(PHASE_MAX), .PHASE_STEP(PHASE_STEP),
    .PHASE_THRESH(PHASE_THRESH), .PHASE_ADJ(PHASE_ADJ)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .recentBits(sampledBits[1:0]), .strobes(strobes)
  );

  afskDatapath #(
    .SAMPLE_W(SAMPLE_W), .DELAY(DELAY), .HIST_W(HIST_W)
  ) uPath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .sampleIn(sampleByte),
    .sampledBits(sampledBits), .bitOut(bitOut), .bitValid(bitValid)
  );
endmodule

// File: rtl/afskDemodChecker.sv
module afskDemodChecker #(
  parameter int ADC_W   = 12,
  parameter int OFS_MIN = 1300,
  parameter int OFS_MAX = 3300
) (
  input logic             clk,
  input logic             rstN,
  input logic             sampleValid,
  input logic             bitValid,
  input logic             bitOut,
  input logic [ADC_W-1:0] offsetValue
);
  // R8
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |=> !bitValid);

  // R8
  strobe_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |-> $past(sampleValid, 3));

  // R7
  held_output_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bitValid |-> $stable(bitOut));

  // R2
  offset_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (offsetValue >= ADC_W'(OFS_MIN)) && (offsetValue <= ADC_W'(OFS_MAX)));
endmodule

bind afskDemodulator afskDemodChecker #(
  .ADC_W(ADC_W), .OFS_MIN(OFS_MIN), .OFS_MAX(OFS_MAX)
) uChk (
  .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
  .bitValid(bitValid), .bitOut(bitOut), .offsetValue(offsetValue)
);

// File: tb/sim_afskDemodulator.sv
module sim_afskDemodulator;
  localparam int CLK_PERIOD = 10;
  localparam int NROWS = 10;
  localparam real MarkStep  = 3.14159265358979 / 4.0;
  localparam real SpaceStep = 2.0 * 3.14159265358979 * 2200.0 / 9600.0;
  // {kind, count, param}: kind 0 = constant level, count samples;
  // kind 1/2/3 = tone pattern, count bits, 8/7/9 samples per bit
  localparam logic [35:0] StimTable [0:NROWS-1] = '{
    {4'd0, 16'd40,  16'd2303},
    {4'd1, 16'd64,  16'hA5C3},
    {4'd2, 16'd48,  16'h7E01},
    {4'd0, 16'd200, 16'd3500},
    {4'd3, 16'd40,  16'h3C96},
    {4'd0, 16'd200, 16'd1300},
    {4'd0, 16'd20,  16'd4095},
    {4'd0, 16'd200, 16'd3300},
    {4'd0, 16'd20,  16'd0},
    {4'd1, 16'd64,  16'hF00F}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleValid = 1'b0;
  logic [11:0] adcSample = '0;
  logic bitValid, bitOut;
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // reference state
  int mOfs, mSum, mCnt, mXp, mYp, mSampled, mPhase, mLast;
  int mDly [4];
  real tonePh;
  bit markTone;

  afskDemodulator u0 (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .adcSample(adcSample),
    .bitValid(bitValid), .bitOut(bitOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic checkVal(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic modelReset();
    mOfs = 2303; mSum = 0; mCnt = 0; mXp = 0; mYp = 0;
    mSampled = 0; mPhase = 0; mLast = 0;
    for (int i = 0; i < 4; i++) mDly[i] = 0;
  endtask

  task automatic modelStep(input int adc, output bit dec, output bit ob);
    int s, prod, xn, yn, ones, lvl;
    s = (adc - mOfs) >>> 4;                               // R1
    if (s > 127) s = 127;
    if (s < -128) s = -128;
    mSum += adc; mCnt++;                                  // R2
    if (mCnt == 192) begin
      mOfs = mSum / 192;
      if (mOfs < 1300 || mOfs > 3300) mOfs = 2303;
      mSum = 0; mCnt = 0;
    end
    prod = s * mDly[3];                                   // R3
    mDly[3] = mDly[2]; mDly[2] = mDly[1]; mDly[1] = mDly[0]; mDly[0] = s;
    xn = (prod * 42) >>> 8;                               // R4
    yn = mXp + xn + ((mYp * 171) >>> 8);
    if (yn > 32767) yn = 32767;
    if (yn < -32768) yn = -32768;
    mXp = xn; mYp = yn;
    mSampled = ((mSampled << 1) | (yn > 0 ? 1 : 0)) & 255;
    if (((mSampled >> 1) ^ mSampled) & 1)                 // R5
      mPhase = (mPhase < 128) ? mPhase + 4 : mPhase - 4;
    mPhase += 32;
    dec = 0; ob = 0;
    if (mPhase >= 256) begin
      mPhase -= 256;
      dec = 1;
      ones = 0;                                           // R6
      for (int b = 0; b < 5; b++) ones += (mSampled >> b) & 1;
      lvl = (ones >= 3) ? 1 : 0;
      ob = (lvl == mLast);                                // R7
      mLast = lvl;
    end
  endtask

  // drive at a falling edge; result due after the third rising edge
  task automatic applySample(input int adc, input bit expDec, input bit expOut, input string req);
    sampleValid = 1'b1;
    adcSample = 12'(adc);
    @(negedge clk);
    sampleValid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    checkVal("R8 strobe timing", bitValid, expDec);
    if (expDec) checkVal(req, bitOut, expOut);
    @(negedge clk);
    checkVal("R8 strobe width", bitValid, 1'b0);
  endtask

  task automatic pushModel(input int adc, input string req);
    bit dec, ob;
    modelStep(adc, dec, ob);
    applySample(adc, dec, ob, req);
  endtask

  // R10: constant input at the offset, independent expectation
  task automatic silenceRun();
    bit dec, ob;
    for (int k = 1; k <= 16; k++) begin
      modelStep(2303, dec, ob);
      applySample(2303, (k % 8) == 0, 1'b1, "R10 idle decision");
    end
  endtask

  task automatic pushTone(input int spb, input bit dataBit);
    int adc;
    if (!dataBit) markTone = !markTone;
    for (int s = 0; s < spb; s++) begin
      tonePh += markTone ? MarkStep : SpaceStep;
      adc = 2303 + $rtoi(1100.0 * $sin(tonePh));
      pushModel(adc, "R3 R4 R5 R6 R7 tone decode");
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      summary();
    end
  end

  initial begin
    modelReset();
    tonePh = 0.0;
    markTone = 1'b1;
    @(negedge clk);
    @(negedge clk);
    checkVal("R9 reset bitValid", bitValid, 1'b0);
    checkVal("R9 reset bitOut", bitOut, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    silenceRun();

    for (int r = 0; r < NROWS; r++) begin
      int kind, cnt, prm;
      kind = int'(StimTable[r][35:32]);
      cnt  = int'(StimTable[r][31:16]);
      prm  = int'(StimTable[r][15:0]);
      if (kind == 0) begin
        for (int n = 0; n < cnt; n++) pushModel(prm, "R1 R2 R7 level input");
      end else begin
        for (int n = 0; n < cnt; n++)
          pushTone(kind == 1 ? 8 : (kind == 2 ? 7 : 9), prm[n % 16]);
      end
    end

    // reset mid-stream clears outputs, offset and decoder history
    rstN = 1'b0;
    @(negedge clk);
    checkVal("R9 mid reset bitValid", bitValid, 1'b0);
    checkVal("R9 mid reset bitOut", bitOut, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    modelReset();
    @(negedge clk);
    silenceRun();

    finished = 1;
    summary();
  end
endmodule